// File: doc/BRIEF.md
# Dual Programmable Interval Timer

Two identical down-counting timers sit behind a small byte-wide register window. Each timer has a 16-bit load value and a 16-bit count. It advances on a base tick (a one-cycle strobe at the 2 MHz rate, supplied from outside) through a prescaler of 1, 2, 4 or 8. When the count reaches its terminal point, the timer either reloads and keeps running or stops. At that point it also raises a pending flag, which appears on a per-timer interrupt output when that timer's interrupt enable is set.

Software reads a 16-bit value one byte at a time. Reading the low byte returns that byte and also captures the whole value. A later high-byte read returns the captured upper byte, so the two bytes always belong together. A control bit picks whether reads return the live count or the programmed load value. A latch-mode bit in either timer switches the window to a global mode. In that mode, one low-byte read of timer 0 captures every timer at the same instant.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both control registers of each timer read 0x00, the count reads 0x0000 and every interrupt output is low.
- R2: Control register A (offset 0) reads as {pending, 0, source[1:0], readsel, prescale[1:0], irq_en}. Bit 7 and bit 6 ignore writes, and bit 6 always reads 0.
- R3: Control register B (offset 1) reads as {000, global_latch, 00, one_shot, enable}. The other bits ignore writes and read 0.
- R4: A write to register B that sets enable while the timer is stopped copies the load value into the count and restarts the prescaler. Each prescaled tick then decrements the count, and the tick that finds the count at zero is the terminal tick. The pending flag therefore rises (load+1)×divisor base ticks after the enabling write.
- R5: Prescale code 00 divides the base tick by 1, 01 by 2, 10 by 4 and 11 by 8.
- R6: With a source code other than 00, the count does not advance.
- R7: With one_shot = 0, the terminal tick reloads the count from the load value and counting continues, so the flag rises again every (load+1)×divisor ticks.
- R8: With one_shot = 1, the terminal tick leaves the count at zero and clears the enable bit, and no further terminal tick occurs.
- R9: The pending flag sets on a terminal tick even when irq_en is 0. The interrupt output equals pending AND irq_en.
- R10: A write of any data to the clear register (offset 2) clears the pending flag. If a terminal tick occurs in the same cycle, the flag stays set.
- R11: With readsel = 1, the byte registers return the load value. With readsel = 0, they return the count.
- R12: A low-byte read (offset 4) returns the low byte of the selected value and captures all 16 bits. A high-byte read (offset 5) returns the upper byte captured by the last capture.
- R13: While either timer's global_latch bit is 1, a low-byte read of timer 0 captures every timer. A low-byte read of any other timer then returns its captured low byte and captures nothing.
- R14: Address bits [3] pick the timer and bits [2:0] the register: 0 control A, 1 control B, 2 clear, 4 low byte, 5 high byte. Writes to offsets 4 and 5 set the load value bytes. Reads of offsets 3, 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base tick strobe, one cycle per base period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads of byte registers have side effects) |
| addr | input | 4 | Register address: timer index and offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during rd_en, otherwise 0 |
| irq | output | 2 | Per-timer interrupt, pending AND enable |

## Verification
The bench builds the block with its defaults: two timers and 16-bit counts. With two timers, the global latch can be observed across timers: a capture of timer 1 caused by a timer 0 read shows up as a stale low byte that differs from the live count. The 16-bit width lets a count that crosses a byte boundary (0x0100 to 0x00FF) show that the high byte comes from the capture. The base tick is held high, so every period equals an exact number of clock edges. These edge counts can be computed from (load+1)×divisor for all four prescale codes.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam logic [2:0] OFS_CTRLA = 3'd0;
  localparam logic [2:0] OFS_CTRLB = 3'd1;
  localparam logic [2:0] OFS_CLR   = 3'd2;
  localparam logic [2:0] OFS_LO    = 3'd4;
  localparam logic [2:0] OFS_HI    = 3'd5;
  localparam logic [1:0] SRC_BASE  = 2'b00;

  typedef struct packed {
    logic [1:0] src;
    logic       rsel;
    logic [1:0] pscl;
    logic       ien;
  } ctrla_t;

  typedef struct packed {
    logic glat;
    logic oshot;
    logic en;
  } ctrlb_t;
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d, last;

  always_comb begin
    last = PC_W'((1 << sel) - 1);
    hit  = run & (pc_q == last);
    pc_d = pc_q;
    if (restart)  pc_d = '0;
    else if (run) pc_d = hit ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/dit_channel.sv
module dit_channel
  import dit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic             wr_clr,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             capture,
  input  logic [7:0]       wdata,
  output logic [7:0]       a_rd,
  output logic [7:0]       b_rd,
  output logic [CNT_W-1:0] live_val,
  output logic [CNT_W-1:0] snap_val,
  output logic             glat_o,
  output logic             irq_o,
  output logic             tc_o,
  output logic             pend_o,
  output logic             en_o,
  output logic             oshot_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int HI_W = CNT_W - 8;

  ctrla_t           ca_q, ca_d;
  ctrlb_t           cb_q, cb_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] load_q, load_d, cnt_q, cnt_d, snap_q, snap_d;
  logic             start, run, step, term;

  assign start = wr_b & wdata[0] & ~cb_q.en;
  assign run   = cb_q.en & tick_i & (ca_q.src == SRC_BASE);

  dit_prescaler #(.SEL_W(2)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .run     (run),
    .sel     (ca_q.pscl),
    .hit     (step)
  );

  assign term     = step & (cnt_q == '0);
  assign live_val = ca_q.rsel ? load_q : cnt_q;

  always_comb begin
    ca_d = wr_a ? ctrla_t'(wdata[5:0]) : ca_q;

    cb_d = cb_q;
    if (wr_b) begin
      cb_d.glat  = wdata[4];
      cb_d.oshot = wdata[1];
      cb_d.en    = wdata[0];
    end else if (term && cb_q.oshot) begin
      cb_d.en = 1'b0;
    end

    load_d = load_q;
    if (wr_lo) load_d[7:0]       = wdata;
    if (wr_hi) load_d[CNT_W-1:8] = wdata[HI_W-1:0];

    cnt_d = cnt_q;
    if (start)     cnt_d = load_q;
    else if (term) cnt_d = cb_q.oshot ? '0 : load_q;
    else if (step) cnt_d = cnt_q - 1'b1;

    if (term)        pend_d = 1'b1;
    else if (wr_clr) pend_d = 1'b0;
    else             pend_d = pend_q;

    snap_d = capture ? live_val : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q   <= '0;
      cb_q   <= '0;
      pend_q <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      ca_q   <= ca_d;
      cb_q   <= cb_d;
      pend_q <= pend_d;
      load_q <= load_d;
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
    end
  end

  assign a_rd     = {pend_q, 1'b0, ca_q};
  assign b_rd     = {3'b000, cb_q.glat, 2'b00, cb_q.oshot, cb_q.en};
  assign snap_val = snap_q;
  assign glat_o   = cb_q.glat;
  assign irq_o    = pend_q & ca_q.ien;
  assign tc_o     = term;
  assign pend_o   = pend_q;
  assign en_o     = cb_q.en;
  assign oshot_o  = cb_q.oshot;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 16,
  parameter int TSEL_W = $clog2(N_TMR),
  parameter int ADDR_W = TSEL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [N_TMR-1:0]  irq
);
  logic [1:0] rsync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  logic [TSEL_W-1:0] tidx;
  logic [2:0]        ofs;
  logic              glob;
  logic [N_TMR-1:0]  glat_v, rd_lo_v, tc_v, pend_v, en_v, os_v;
  logic [N_TMR-1:0][CNT_W-1:0] cnt_v;
  logic [7:0]        a_rd   [N_TMR];
  logic [7:0]        b_rd   [N_TMR];
  logic [CNT_W-1:0]  live_v [N_TMR];
  logic [CNT_W-1:0]  snap_v [N_TMR];

  assign tidx = addr[ADDR_W-1:3];
  assign ofs  = addr[2:0];
  assign glob = |glat_v;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic hit, cap;
    assign hit        = (tidx == TSEL_W'(i));
    assign rd_lo_v[i] = rd_en & hit & (ofs == OFS_LO);
    assign cap        = glob ? rd_lo_v[0] : rd_lo_v[i];

    dit_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_ns),
      .tick_i   (tick_i),
      .wr_a     (wr_en & hit & (ofs == OFS_CTRLA)),
      .wr_b     (wr_en & hit & (ofs == OFS_CTRLB)),
      .wr_clr   (wr_en & hit & (ofs == OFS_CLR)),
      .wr_lo    (wr_en & hit & (ofs == OFS_LO)),
      .wr_hi    (wr_en & hit & (ofs == OFS_HI)),
      .capture  (cap),
      .wdata    (wdata),
      .a_rd     (a_rd[i]),
      .b_rd     (b_rd[i]),
      .live_val (live_v[i]),
      .snap_val (snap_v[i]),
      .glat_o   (glat_v[i]),
      .irq_o    (irq[i]),
      .tc_o     (tc_v[i]),
      .pend_o   (pend_v[i]),
      .en_o     (en_v[i]),
      .oshot_o  (os_v[i]),
      .cnt_o    (cnt_v[i])
    );
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en && (int'(tidx) < N_TMR)) begin
      case (ofs)
        OFS_CTRLA: rdata = a_rd[tidx];
        OFS_CTRLB: rdata = b_rd[tidx];
        OFS_LO:    rdata = (glob && tidx != '0) ? snap_v[tidx][7:0] : live_v[tidx][7:0];
        OFS_HI:    rdata = 8'(snap_v[tidx] >> 8);
        default:   rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int N_TMR  = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [7:0]                  rdata,
  input logic [N_TMR-1:0]            tc_v,
  input logic [N_TMR-1:0]            pend_v,
  input logic [N_TMR-1:0]            en_v,
  input logic [N_TMR-1:0]            os_v,
  input logic [N_TMR-1:0][CNT_W-1:0] cnt_v
);
  logic tmr_ok;
  assign tmr_ok = int'(addr[ADDR_W-1:3]) < N_TMR;

  // R2
  ctrla_bit6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && tmr_ok && addr[2:0] == 3'd0) |-> ((rdata & 8'h40) == 8'h00));

  // R3
  ctrlb_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && tmr_ok && addr[2:0] == 3'd1) |-> ((rdata & 8'hEC) == 8'h00));

  for (genvar i = 0; i < N_TMR; i++) begin : g_chk
    localparam int unsigned A_B   = i * 8 + 1;
    localparam int unsigned A_CLR = i * 8 + 2;
    logic wb, wc;
    assign wb = wr_en && (addr == ADDR_W'(A_B));
    assign wc = wr_en && (addr == ADDR_W'(A_CLR));

    // R10
    term_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_v[i] |=> pend_v[i]);

    // R10
    clr_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wc && !tc_v[i]) |=> !pend_v[i]);

    // R8
    oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_v[i] && os_v[i] && !wb) |=> !en_v[i]);

    // R4
    idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_v[i] && !wb) |=> $stable(cnt_v[i]));
  end
endmodule

bind dual_interval_timer dit_checker #(
  .N_TMR  (N_TMR),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .rdata  (rdata),
  .tc_v   (tc_v),
  .pend_v (pend_v),
  .en_v   (en_v),
  .os_v   (os_v),
  .cnt_v  (cnt_v)
);

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dual_interval_timer u_dut (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .wr_en (wr_en),
    .rd_en (rd_en), .addr (addr), .wdata (wdata), .rdata (rdata), .irq (irq)
  );

  // period vectors: prescale code, load value, expected edges to flag
  localparam int NV = 5;
  localparam int V_DIV  [NV] = '{0, 1, 2, 3, 0};
  localparam int V_LOAD [NV] = '{5, 3, 2, 1, 0};
  localparam int V_EXP  [NV] = '{6, 8, 12, 16, 1};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic wait_irq0(inout int n);
    while (n < 300) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (irq[0]) break;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    br(4'h0, d); check("R1 ctrlA", d, 8'h00);
    br(4'h1, d); check("R1 ctrlB", d, 8'h00);
    br(4'h4, d); check("R1 count", d, 8'h00);
    check("R1 irq", irq, 0);

    // R4 R5 R7: period table on timer 0
    for (int v = 0; v < NV; v++) begin
      bw(4'h1, 8'h00);
      bw(4'h2, 8'h00);
      bw(4'h0, 8'((V_DIV[v] << 1) | 1));
      bw(4'h4, 8'(V_LOAD[v]));
      bw(4'h5, 8'h00);
      bw(4'h1, 8'h01);
      n = 0;
      wait_irq0(n);
      check($sformatf("R4 R5 period vec%0d", v), n, V_EXP[v]);
    end

    // R8 one-shot
    bw(4'h1, 8'h00); bw(4'h2, 8'h00);
    bw(4'h0, 8'h01); bw(4'h4, 8'h02); bw(4'h5, 8'h00);
    bw(4'h1, 8'h03);
    n = 0; wait_irq0(n);
    check("R8 oneshot period", n, 3);
    br(4'h1, d); check("R8 enable cleared", d, 8'h02);
    bw(4'h2, 8'hA5);
    repeat (10) @(posedge clk);
    @(negedge clk); check("R8 no second flag", irq[0], 0);
    br(4'h4, d); check("R8 count stays zero", d, 8'h00);

    // R7 reload continues
    bw(4'h1, 8'h00); bw(4'h2, 8'h00);
    bw(4'h0, 8'h01); bw(4'h4, 8'h05); bw(4'h5, 8'h00);
    bw(4'h1, 8'h01);
    n = 0; wait_irq0(n);
    check("R7 first flag", n, 6);
    bw(4'h2, 8'h3C);
    n += 2;
    @(negedge clk); check("R7 cleared", irq[0], 0);
    wait_irq0(n);
    check("R7 second flag", n, 12);

    // R12 coherent byte read across a byte boundary
    bw(4'h1, 8'h00); bw(4'h2, 8'h00); bw(4'h0, 8'h00);
    bw(4'h4, 8'h00); bw(4'h5, 8'h01);
    bw(4'h1, 8'h01);
    br(4'h4, d); check("R12 low byte", d, 8'h00);
    br(4'h5, d); check("R12 captured high", d, 8'h01);
    br(4'h4, d); check("R12 live low", d, 8'hFE);

    // R11 read select returns load value
    bw(4'h1, 8'h00); bw(4'h0, 8'h08);
    bw(4'h4, 8'h5A); bw(4'h5, 8'hA5);
    br(4'h4, d); check("R11 load low", d, 8'h5A);
    br(4'h5, d); check("R11 load high", d, 8'hA5);
    br(4'h0, d); check("R2 ctrlA readback", d, 8'h08);

    // R10 clear write loses to a simultaneous terminal tick
    bw(4'h1, 8'h00); bw(4'h2, 8'h00);
    bw(4'h0, 8'h01); bw(4'h4, 8'h00); bw(4'h5, 8'h00);
    bw(4'h1, 8'h01);
    repeat (3) @(posedge clk);
    bw(4'h2, 8'h00);
    br(4'h0, d); check("R10 set wins", d, 8'h81);
    bw(4'h1, 8'h00);
    bw(4'h2, 8'h77);
    br(4'h0, d); check("R10 any data clears", d, 8'h01);
    check("R10 irq low", irq[0], 0);

    // R9 masked flag
    bw(4'h0, 8'h00); bw(4'h4, 8'h01);
    bw(4'h1, 8'h01);
    repeat (6) @(posedge clk);
    @(negedge clk); check("R9 masked irq", irq[0], 0);
    br(4'h0, d); check("R9 pending while masked", d, 8'h80);
    bw(4'h0, 8'h01);
    @(negedge clk); check("R9 irq on unmask", irq[0], 1);
    bw(4'h1, 8'h00); bw(4'h2, 8'h00); bw(4'h0, 8'h00);

    // R6 reserved source halts counting
    bw(4'h0, 8'h10); bw(4'h4, 8'h03); bw(4'h5, 8'h00);
    bw(4'h1, 8'h01);
    repeat (20) @(posedge clk);
    br(4'h4, d); check("R6 count held", d, 8'h03);
    br(4'h0, d); check("R6 source readback", d, 8'h10);
    bw(4'h1, 8'h00); bw(4'h0, 8'h00);

    // R2 R3 field layout on timer 1
    bw(4'h8, 8'hFF);
    br(4'h8, d); check("R2 ctrlA fields", d, 8'h3F);
    bw(4'h8, 8'h00);
    bw(4'h9, 8'hEC);
    br(4'h9, d); check("R3 reserved ignored", d, 8'h00);
    bw(4'h9, 8'h12);
    br(4'h9, d); check("R3 ctrlB fields", d, 8'h12);
    bw(4'h9, 8'h00);

    // R13 global latch set through timer 1
    bw(4'hC, 8'h50); bw(4'hD, 8'h00); bw(4'h8, 8'h00);
    bw(4'h9, 8'h11);
    br(4'h4, d);
    br(4'hC, d); check("R13 timer1 captured low", d, 8'h50);
    br(4'hD, d); check("R13 timer1 captured high", d, 8'h00);
    bw(4'h9, 8'h01);
    br(4'hC, d); check("R13 local mode live low", d, 8'h4C);

    // R14 unmapped offsets
    br(4'h3, d); check("R14 offset3", d, 8'h00);
    br(4'h6, d); check("R14 offset6", d, 8'h00);
    br(4'hF, d); check("R14 offset7", d, 8'h00);

    finish_run();
  end
endmodule